// File: doc/BRIEF.md
# Raw Blanking-Interval Sample Gate

This block chooses, sample by sample, which incoming video samples are passed to the pixel output as raw vertical-blanking-interval data, so that software can decode teletext, captions or test signals from them. Each cycle it receives the frame line number, the field, a video standard select and the sample position within the line. It also receives a per-line selection mask, an all-lines enable, an inclusive sample window and the blanking level.

A sample passes only when three things hold. Its line must not be one of the always-blanked equalization and serration lines of the selected standard. The line must be selected, either through the all-lines enable or through a mask bit over the blanking-interval lines of its field. Its position must lie inside the window. A passed sample leaves with the blanking level removed, clamped at zero. One register stage holds both the strobe and the data.

Top module: `raw_vbi_gate`

## Requirements
- R1: During reset and in the first cycle after it, `cap_valid` is 0 and `cap_data` is 0.
- R2: With `std_sel` = 0 (525-line, 60 Hz colour system), lines 1-9 and 264-271 never produce output, even with `all_lines` set. The mask-eligible lines are 10-21 when `field` = 0 and 272-284 when `field` = 1.
- R3: With `std_sel` = 1 (625-line system), lines 623-625, 1-5 and 311-317 never produce output. The mask-eligible lines are 6-22 when `field` = 0 and 318-335 when `field` = 1.
- R4: With `std_sel` = 2 (525-line variant of the 625-line colour system), lines 523-525, 1-6 and 261-268 never produce output. The mask-eligible lines are 7-21 when `field` = 0 and 269-284 when `field` = 1.
- R5: With `all_lines` = 0, a line is selected only when it lies in the eligible range of the current field and bit k of `line_mask` is 1, where k = line − first eligible line of that field. Lines outside the range are never selected.
- R6: With `all_lines` = 1, every line that is not always-blanked is selected, including active-video lines, whatever the values of `field` and `line_mask`.
- R7: On a selected line, a sample is captured when `win_start` ≤ `samp_pos` ≤ `win_end`. When `win_end` < `win_start`, nothing on the line is captured.
- R8: `cap_data` equals `samp_in` − `blank_lvl` for a captured sample, and 0 when `samp_in` ≤ `blank_lvl`.
- R9: Both outputs follow the inputs sampled at the previous rising clock edge, and `cap_data` is 0 whenever `cap_valid` is 0.
- R10: `std_sel` = 3 is reserved, and no sample is ever captured under it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_sel | input | 2 | Video standard: 0 525/60, 1 625/50, 2 525 variant, 3 reserved |
| field | input | 1 | Current field, 0 first, 1 second |
| line_num | input | 10 | Frame line number, 1-based |
| samp_pos | input | 11 | Sample index within the line |
| line_mask | input | 20 | Per-line select bits over the field's eligible lines |
| all_lines | input | 1 | Treat every non-blanked line as raw data |
| win_start | input | 11 | First captured sample index, inclusive |
| win_end | input | 11 | Last captured sample index, inclusive |
| blank_lvl | input | 10 | Blanking level to subtract |
| samp_in | input | 10 | Incoming video sample |
| cap_valid | output | 1 | Registered capture strobe |
| cap_data | output | 10 | Registered sample minus blanking level |

## Verification
All state sits in one register stage. A wrong line limit, a mis-indexed mask bit or an off-by-one window edge therefore shows at `cap_valid` one clock after the offending sample, and the stimulus concentrates on the exact first and last lines and the window edges. A wrong subtraction or a missing clamp shows in `cap_data` on that same cycle. A stale strobe shows as nonzero data while `cap_valid` is low.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
    typedef enum logic [1:0] {
        STD_525   = 2'd0,
        STD_625   = 2'd1,
        STD_525V  = 2'd2,
        STD_RSVD  = 2'd3
    } vstd_e;
endpackage

// File: rtl/vbi_line_qual.sv
module vbi_line_qual
    import vbi_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int MASK_W = 20
) (
    input  vstd_e               std_sel,
    input  logic                field,
    input  logic [LINE_W-1:0]   line_num,
    input  logic [MASK_W-1:0]   line_mask,
    input  logic                all_lines,
    output logic                blanked,
    output logic                line_sel
);
    localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

    logic              known;
    logic [LINE_W-1:0] first_l, last_l, offs;
    logic              mask_hit;

    always_comb begin
        known   = 1'b1;
        blanked = 1'b0;
        first_l = '0;
        last_l  = '0;
        unique case (std_sel)
            STD_525: begin
                blanked = (line_num >= LINE_W'(1)   && line_num <= LINE_W'(9)) ||
                          (line_num >= LINE_W'(264) && line_num <= LINE_W'(271));
                first_l = field ? LINE_W'(272) : LINE_W'(10);
                last_l  = field ? LINE_W'(284) : LINE_W'(21);
            end
            STD_625: begin
                blanked = (line_num >= LINE_W'(623) || line_num <= LINE_W'(5)) ||
                          (line_num >= LINE_W'(311) && line_num <= LINE_W'(317));
                first_l = field ? LINE_W'(318) : LINE_W'(6);
                last_l  = field ? LINE_W'(335) : LINE_W'(22);
            end
            STD_525V: begin
                blanked = (line_num >= LINE_W'(523) || line_num <= LINE_W'(6)) ||
                          (line_num >= LINE_W'(261) && line_num <= LINE_W'(268));
                first_l = field ? LINE_W'(269) : LINE_W'(7);
                last_l  = field ? LINE_W'(284) : LINE_W'(21);
            end
            default: known = 1'b0;
        endcase
    end

    always_comb begin
        offs     = line_num - first_l;
        mask_hit = 1'b0;
        if (line_num >= first_l && line_num <= last_l && offs < LINE_W'(MASK_W))
            mask_hit = line_mask[offs[IDX_W-1:0]];
        line_sel = known && !blanked && (all_lines || mask_hit);
    end
endmodule

// File: rtl/vbi_win_cmp.sv
module vbi_win_cmp #(
    parameter int POS_W = 11
) (
    input  logic [POS_W-1:0] samp_pos,
    input  logic [POS_W-1:0] win_start,
    input  logic [POS_W-1:0] win_end,
    output logic             in_win
);
    always_comb in_win = (samp_pos >= win_start) && (samp_pos <= win_end);
endmodule

// File: rtl/vbi_blank_sub.sv
module vbi_blank_sub #(
    parameter int SMP_W = 10
) (
    input  logic [SMP_W-1:0] samp_in,
    input  logic [SMP_W-1:0] blank_lvl,
    output logic [SMP_W-1:0] diff
);
    always_comb diff = (samp_in > blank_lvl) ? (samp_in - blank_lvl) : '0;
endmodule

// File: rtl/raw_vbi_gate.sv
module raw_vbi_gate
    import vbi_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int POS_W  = 11,
    parameter int SMP_W  = 10,
    parameter int MASK_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        std_sel,
    input  logic              field,
    input  logic [LINE_W-1:0] line_num,
    input  logic [POS_W-1:0]  samp_pos,
    input  logic [MASK_W-1:0] line_mask,
    input  logic              all_lines,
    input  logic [POS_W-1:0]  win_start,
    input  logic [POS_W-1:0]  win_end,
    input  logic [SMP_W-1:0]  blank_lvl,
    input  logic [SMP_W-1:0]  samp_in,
    output logic              cap_valid,
    output logic [SMP_W-1:0]  cap_data
);
    typedef struct packed {
        logic             valid;
        logic [SMP_W-1:0] data;
    } cap_t;

    cap_t       st_d, st_q;
    logic       blanked, line_sel, in_win;
    logic [SMP_W-1:0] diff;

    vbi_line_qual #(.LINE_W(LINE_W), .MASK_W(MASK_W)) u_qual (
        .std_sel  (vstd_e'(std_sel)),
        .field    (field),
        .line_num (line_num),
        .line_mask(line_mask),
        .all_lines(all_lines),
        .blanked  (blanked),
        .line_sel (line_sel)
    );

    vbi_win_cmp #(.POS_W(POS_W)) u_win (
        .samp_pos (samp_pos),
        .win_start(win_start),
        .win_end  (win_end),
        .in_win   (in_win)
    );

    vbi_blank_sub #(.SMP_W(SMP_W)) u_sub (
        .samp_in  (samp_in),
        .blank_lvl(blank_lvl),
        .diff     (diff)
    );

    always_comb begin
        st_d.valid = line_sel && in_win;
        st_d.data  = st_d.valid ? diff : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_valid = st_q.valid;
    assign cap_data  = st_q.data;

    // R9
    no_data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |-> cap_data == '0);

    // R7
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> ($past(samp_pos) >= $past(win_start) && $past(samp_pos) <= $past(win_end)));

    // R2
    blanked_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> !$past(blanked));

    // R10
    reserved_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> $past(std_sel) != 2'd3);

    // R8
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && $past(samp_in) <= $past(blank_lvl)) |-> cap_data == '0);

    // R8
    subtract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && $past(samp_in) > $past(blank_lvl)) |->
            cap_data == SMP_W'($past(samp_in) - $past(blank_lvl)));
endmodule

// File: tb/raw_vbi_gate_bench.sv
module raw_vbi_gate_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  std_sel = '0;
    logic        field = 1'b0;
    logic [9:0]  line_num = 10'd1;
    logic [10:0] samp_pos = '0;
    logic [19:0] line_mask = '0;
    logic        all_lines = 1'b0;
    logic [10:0] win_start = '0;
    logic [10:0] win_end = '0;
    logic [9:0]  blank_lvl = '0;
    logic [9:0]  samp_in = '0;
    logic        cap_valid;
    logic [9:0]  cap_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raw_vbi_gate u_raw_vbi_gate (
        .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .field(field),
        .line_num(line_num), .samp_pos(samp_pos), .line_mask(line_mask),
        .all_lines(all_lines), .win_start(win_start), .win_end(win_end),
        .blank_lvl(blank_lvl), .samp_in(samp_in),
        .cap_valid(cap_valid), .cap_data(cap_data)
    );

    typedef struct packed {
        logic [1:0]  sd;
        logic        fl;
        logic [9:0]  ln;
        logic [19:0] mk;
        logic        al;
        logic [10:0] ws;
        logic [10:0] we;
        logic [10:0] ps;
        logic [9:0]  bl;
        logic [9:0]  sm;
        logic        ev;
        logic [9:0]  ed;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t TBL [NV] = '{
        // R2 525-line limits
        '{2'd0,1'b0,10'd9,  20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd2},
        '{2'd0,1'b0,10'd10, 20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd2},
        '{2'd0,1'b1,10'd271,20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd2},
        '{2'd0,1'b1,10'd272,20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd2},
        '{2'd0,1'b0,10'd1,  20'hFFFFF,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd2},
        '{2'd0,1'b1,10'd264,20'hFFFFF,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd2},
        // R6 all-lines mode
        '{2'd0,1'b0,10'd100,20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd6},
        '{2'd0,1'b1,10'd10, 20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd6},
        // R5 mask mode
        '{2'd0,1'b0,10'd100,20'hFFFFF,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd5},
        '{2'd0,1'b0,10'd12, 20'h00004,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd5},
        '{2'd0,1'b0,10'd13, 20'h00004,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd5},
        '{2'd0,1'b1,10'd274,20'h00004,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd5},
        '{2'd0,1'b1,10'd12, 20'h00004,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd5},
        '{2'd0,1'b0,10'd21, 20'h00800,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd5},
        '{2'd0,1'b0,10'd22, 20'hFFFFF,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd5},
        '{2'd0,1'b1,10'd284,20'h01000,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd2},
        // R3 625-line limits
        '{2'd1,1'b0,10'd5,  20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd3},
        '{2'd1,1'b0,10'd6,  20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd3},
        '{2'd1,1'b1,10'd624,20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd3},
        '{2'd1,1'b1,10'd622,20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd3},
        '{2'd1,1'b1,10'd317,20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd3},
        '{2'd1,1'b1,10'd318,20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd3},
        '{2'd1,1'b0,10'd22, 20'h10000,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd3},
        '{2'd1,1'b0,10'd23, 20'hFFFFF,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd3},
        '{2'd1,1'b1,10'd335,20'h20000,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd3},
        // R4 525-line variant limits
        '{2'd2,1'b0,10'd6,  20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd4},
        '{2'd2,1'b0,10'd7,  20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd4},
        '{2'd2,1'b1,10'd268,20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd4},
        '{2'd2,1'b1,10'd269,20'h00001,1'b0,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd4},
        '{2'd2,1'b1,10'd523,20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd4},
        '{2'd2,1'b1,10'd522,20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd200,1'b1,10'd136,8'd4},
        // R7 window edges
        '{2'd0,1'b0,10'd50, 20'h00000,1'b1,11'd100,11'd900,11'd100,10'd64,10'd200,1'b1,10'd136,8'd7},
        '{2'd0,1'b0,10'd50, 20'h00000,1'b1,11'd100,11'd900,11'd900,10'd64,10'd200,1'b1,10'd136,8'd7},
        '{2'd0,1'b0,10'd50, 20'h00000,1'b1,11'd100,11'd900,11'd99, 10'd64,10'd200,1'b0,10'd0,  8'd7},
        '{2'd0,1'b0,10'd50, 20'h00000,1'b1,11'd100,11'd900,11'd901,10'd64,10'd200,1'b0,10'd0,  8'd7},
        '{2'd0,1'b0,10'd50, 20'h00000,1'b1,11'd600,11'd400,11'd500,10'd64,10'd200,1'b0,10'd0,  8'd7},
        // R8 subtraction and clamp
        '{2'd0,1'b0,10'd50, 20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd50, 1'b1,10'd0,  8'd8},
        '{2'd0,1'b0,10'd50, 20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd64, 1'b1,10'd0,  8'd8},
        '{2'd0,1'b0,10'd50, 20'h00000,1'b1,11'd100,11'd900,11'd500,10'd64,10'd65, 1'b1,10'd1,  8'd8},
        // R10 reserved standard
        '{2'd3,1'b0,10'd50, 20'hFFFFF,1'b1,11'd0,  11'd2047,11'd500,10'd0,10'd200,1'b1 ^ 1'b1,10'd0,8'd10}
    };

    task automatic check(input string tag, input logic ev, input logic [9:0] ed);
        n_chk++;
        if (cap_valid !== ev || cap_data !== ed) begin
            n_bad++;
            $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                     tag, cap_valid, cap_data, ev, ed);
        end
    endtask

    task automatic apply(input vec_t v);
        std_sel = v.sd; field = v.fl; line_num = v.ln; line_mask = v.mk;
        all_lines = v.al; win_start = v.ws; win_end = v.we; samp_pos = v.ps;
        blank_lvl = v.bl; samp_in = v.sm;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state, with a capturable line on the inputs
        apply(TBL[1]);
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 10'd0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(TBL[0]);
        check("R1 first cycle after reset", 1'b0, 10'd0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].ev, TBL[i].ed);
        end

        // R9 one-cycle latency: output holds old value until the edge
        apply(TBL[0]);
        @(negedge clk);
        apply(TBL[1]);
        #1;
        check("R9 no change before edge", 1'b0, 10'd0);
        @(negedge clk);
        check("R9 follows after one edge", 1'b1, 10'd136);
        apply(TBL[0]);
        @(negedge clk);
        check("R9 data cleared with strobe", 1'b0, 10'd0);

        // R1 mid-run reset clears a live capture
        apply(TBL[1]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears outputs", 1'b0, 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 resumes after reset", 1'b1, 10'd136);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule